// File: doc/BRIEF.md
# Asynchronous Serial Port with Handshake and Break Detection

This block is a full-duplex asynchronous serial port. Both directions are timed from one 16x oversampling tick, which a programmable 16-bit divisor derives from the core clock. A character has one start bit and 7, 8 or 9 data bits, sent least significant bit first. Even or odd parity is optional, and one stop bit closes the frame. Software drives the block through a small word-wide register port with five locations: control, status, transmit, receive and divisor. Status flags report receive errors and two classes of line break.

When handshaking is enabled, the port holds its ready-to-receive output low until software has read the previous character. It also keeps a written character in the transmit holding register for as long as the peer's ready input is low. The transmitter runs the states T_IDLE, T_START, T_DATA, T_PAR and T_STOP, and moves only on oversampling ticks. T_IDLE goes to T_START when a held character may leave. T_START goes to T_DATA after 16 ticks. T_DATA goes to T_PAR or T_STOP after the last data bit. T_PAR goes to T_STOP. T_STOP returns to T_IDLE.

The receiver runs the states R_IDLE, R_START, R_DATA, R_PAR, R_STOP and R_WAITHI. R_IDLE goes to R_START when the synchronized line falls. R_START goes to R_DATA if the line is still low 8 ticks later, and otherwise falls back to R_IDLE. R_DATA goes to R_PAR or R_STOP after the last data bit. R_PAR goes to R_STOP. R_STOP returns to R_IDLE when a high stop bit is sampled, and otherwise goes to R_WAITHI. R_WAITHI returns to R_IDLE once the line is high.

Top module: `serial_link`

## Requirements
- R1: With divisor D in the divisor register (address 4), every bit on the serial output lasts exactly 16*D clocks. A divisor of 0 acts as 1.
- R2: A transmitted frame is one low start bit, then the data bits LSB first, then an optional parity bit, then one high stop bit. Control bits select the data width: bit 2 = 1 gives 8 bits and 0 gives 7, and bit 6 = 1 gives 9 bits. Control bit 3 enables parity and bit 4 selects odd parity (1) or even parity (0). Even parity makes the count of ones in data plus parity even. The line is high while no frame is being sent.
- R3: Status bit 1 (holding empty) is 0 from a write to the transmit register (address 2) until the character moves into the shifter. Status bit 2 (transmitter empty) is 1 only when both the holding register and the shifter are empty.
- R4: A received character is stored in the receive register (address 3), and status bit 0 (data ready) is set. A read of address 3 clears data ready.
- R5: A received parity bit that does not match the selected parity sets status bit 3.
- R6: A low stop bit sets status bit 4 (framing error).
- R7: A character that completes while data ready is set sets status bit 5 (overrun), and the new character replaces the old one.
- R8: Status bits 3 to 7 stay set until software writes a 1 to the same bit of the status register.
- R9: The ready output equals handshake enable (control bit 5) AND receive enable (control bit 1) AND NOT data ready. It therefore stays low from the end of a character until that character is read.
- R10: With handshaking enabled, no frame starts while the synchronized peer-ready input is low, and the character stays in the holding register.
- R11: When the receive line stays low for 2M+3 bit times, status bit 6 (long break) is set, where M is the frame length in bits. It is not set after 2M+2 bit times.
- R12: A frame whose data, parity and stop bits are all low sets status bit 7 (short break) together with the framing error.
- R13: In 9-bit mode, control bit 7 supplies the transmitted ninth bit, receive register bit 8 returns the received ninth bit, and parity is neither sent nor checked.
- R14: After reset, status reads 0x0006, control reads 0, the serial output is high and the ready output is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (side effect on receive register) |
| bus_addr | input | 3 | Register address: 0 control, 1 status, 2 transmit, 3 receive, 4 divisor |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for the addressed register |
| rxd_i | input | 1 | Serial receive line |
| txd_o | output | 1 | Serial transmit line |
| peer_rdy_i | input | 1 | Peer ready to accept a character (active high) |
| rx_rdy_o | output | 1 | This port ready to accept a character (active high) |

## Verification
A transmit state machine that moves at the wrong moment shows up on the serial line within one bit time, as a bit of the wrong length or value. The bench compares the line against its own expected waveform on every clock, so the fault is caught there. A receive state machine that samples off centre, or counts bits wrongly, leaves a wrong character or flag, and this is visible in the first status and receive read after the frame ends. Handshake faults appear at once on the ready output, or as a start bit that leaves while the peer is not ready.

// File: rtl/serial_link_pkg.sv
package serial_link_pkg;

    localparam int unsigned BUS_W  = 16;
    localparam int unsigned ADDR_W = 3;

    localparam logic [ADDR_W-1:0] A_CTRL = 3'd0;
    localparam logic [ADDR_W-1:0] A_STAT = 3'd1;
    localparam logic [ADDR_W-1:0] A_TXD  = 3'd2;
    localparam logic [ADDR_W-1:0] A_RXD  = 3'd3;
    localparam logic [ADDR_W-1:0] A_BAUD = 3'd4;

    typedef enum logic [2:0] {
        T_IDLE, T_START, T_DATA, T_PAR, T_STOP
    } tx_state_t;

    typedef enum logic [2:0] {
        R_IDLE, R_START, R_DATA, R_PAR, R_STOP, R_WAITHI
    } rx_state_t;

    // control register layout, MSB first
    typedef struct packed {
        logic tb8;
        logic nine;
        logic hs_en;
        logic par_odd;
        logic par_en;
        logic len8;
        logic rx_en;
        logic tx_en;
    } ctrl_t;

    function automatic logic [3:0] data_bits(input ctrl_t c);
        if (c.nine)      return 4'd9;
        else if (c.len8) return 4'd8;
        else             return 4'd7;
    endfunction

    function automatic logic parity_on(input ctrl_t c);
        return c.par_en & ~c.nine;
    endfunction

endpackage

// File: rtl/sl_baud_gen.sv
module sl_baud_gen #(
    parameter int unsigned DIV_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [DIV_W-1:0] div,
    output logic             tick
);
    logic [DIV_W-1:0] cnt;

    always_comb begin
        tick = (div == '0) || (cnt >= div - DIV_W'(1));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    cnt <= '0;
        else if (tick) cnt <= '0;
        else           cnt <= cnt + DIV_W'(1);
    end
endmodule

// File: rtl/sl_tx.sv
module sl_tx
    import serial_link_pkg::*;
#(
    parameter int unsigned OVS = 16
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick,
    input  logic       go_ok,
    input  logic [3:0] nb,
    input  logic       par_on,
    input  logic       par_odd,
    input  logic       hold_valid,
    input  logic [8:0] hold_data,
    output logic       take,
    output logic       txd,
    output logic       busy
);
    localparam int unsigned SUB_W = $clog2(OVS);
    localparam logic [SUB_W-1:0] SUB_LAST = SUB_W'(OVS - 1);

    tx_state_t        state;
    logic [SUB_W-1:0] sub;
    logic [3:0]       bitn;
    logic [8:0]       shreg;
    logic             parb;

    // state register and datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= T_IDLE;
            sub   <= '0;
            bitn  <= '0;
            shreg <= '0;
            parb  <= 1'b0;
        end else if (tick) begin
            unique case (state)
                T_IDLE: begin
                    if (take) begin
                        state <= T_START;
                        sub   <= '0;
                        shreg <= hold_data;
                        parb  <= (^hold_data) ^ par_odd;
                    end
                end
                T_START: begin
                    if (sub == SUB_LAST) begin
                        sub   <= '0;
                        bitn  <= '0;
                        state <= T_DATA;
                    end else begin
                        sub <= sub + SUB_W'(1);
                    end
                end
                T_DATA: begin
                    if (sub == SUB_LAST) begin
                        sub   <= '0;
                        shreg <= shreg >> 1;
                        if (bitn == nb - 4'd1) state <= par_on ? T_PAR : T_STOP;
                        else                   bitn  <= bitn + 4'd1;
                    end else begin
                        sub <= sub + SUB_W'(1);
                    end
                end
                T_PAR: begin
                    if (sub == SUB_LAST) begin
                        sub   <= '0;
                        state <= T_STOP;
                    end else begin
                        sub <= sub + SUB_W'(1);
                    end
                end
                T_STOP: begin
                    if (sub == SUB_LAST) begin
                        sub   <= '0;
                        state <= T_IDLE;
                    end else begin
                        sub <= sub + SUB_W'(1);
                    end
                end
                default: state <= T_IDLE;
            endcase
        end
    end

    // outputs
    always_comb begin
        take = tick && (state == T_IDLE) && hold_valid && go_ok;
        busy = (state != T_IDLE);
        unique case (state)
            T_START: txd = 1'b0;
            T_DATA:  txd = shreg[0];
            T_PAR:   txd = parb;
            default: txd = 1'b1;
        endcase
    end
endmodule

// File: rtl/sl_rx.sv
module sl_rx
    import serial_link_pkg::*;
#(
    parameter int unsigned OVS    = 16,
    parameter int unsigned MAX_M  = 12
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick,
    input  logic       rx_en,
    input  logic [3:0] nb,
    input  logic       par_on,
    input  logic       par_odd,
    input  logic       rx_s,
    output logic       done,
    output logic [8:0] dout,
    output logic       perr_o,
    output logic       ferr_o,
    output logic       sbrk_o,
    output logic       lbrk_o
);
    localparam int unsigned SUB_W   = $clog2(OVS);
    localparam int unsigned LOW_MAX = (2 * MAX_M + 3) * OVS;
    localparam int unsigned LOW_W   = $clog2(LOW_MAX + 1);
    localparam logic [SUB_W-1:0] SUB_LAST = SUB_W'(OVS - 1);
    localparam logic [SUB_W-1:0] SUB_MID  = SUB_W'(OVS / 2 - 1);

    rx_state_t        state;
    logic [SUB_W-1:0] sub;
    logic [3:0]       bitn;
    logic [8:0]       data;
    logic             ones;
    logic             any1;
    logic             pe;
    logic [LOW_W-1:0] lowcnt;
    logic [LOW_W-1:0] thresh;

    always_comb begin
        int unsigned m;
        m      = 2 + int'(nb) + (par_on ? 1 : 0);
        thresh = LOW_W'((2 * m + 3) * OVS);
    end

    // frame state machine
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state  <= R_IDLE;
            sub    <= '0;
            bitn   <= '0;
            data   <= '0;
            ones   <= 1'b0;
            any1   <= 1'b0;
            pe     <= 1'b0;
            done   <= 1'b0;
            dout   <= '0;
            perr_o <= 1'b0;
            ferr_o <= 1'b0;
            sbrk_o <= 1'b0;
        end else begin
            done   <= 1'b0;
            perr_o <= 1'b0;
            ferr_o <= 1'b0;
            sbrk_o <= 1'b0;
            if (!rx_en) begin
                state <= R_IDLE;
            end else begin
                unique case (state)
                    R_IDLE: begin
                        if (!rx_s) begin
                            state <= R_START;
                            sub   <= '0;
                        end
                    end
                    R_START: begin
                        if (tick) begin
                            if (sub == SUB_MID) begin
                                sub <= '0;
                                if (!rx_s) begin
                                    state <= R_DATA;
                                    bitn  <= '0;
                                    data  <= '0;
                                    ones  <= 1'b0;
                                    any1  <= 1'b0;
                                    pe    <= 1'b0;
                                end else begin
                                    state <= R_IDLE;
                                end
                            end else begin
                                sub <= sub + SUB_W'(1);
                            end
                        end
                    end
                    R_DATA: begin
                        if (tick) begin
                            if (sub == SUB_LAST) begin
                                sub        <= '0;
                                data[bitn] <= rx_s;
                                ones       <= ones ^ rx_s;
                                any1       <= any1 | rx_s;
                                if (bitn == nb - 4'd1) state <= par_on ? R_PAR : R_STOP;
                                else                   bitn  <= bitn + 4'd1;
                            end else begin
                                sub <= sub + SUB_W'(1);
                            end
                        end
                    end
                    R_PAR: begin
                        if (tick) begin
                            if (sub == SUB_LAST) begin
                                sub   <= '0;
                                pe    <= ones ^ rx_s ^ par_odd;
                                any1  <= any1 | rx_s;
                                state <= R_STOP;
                            end else begin
                                sub <= sub + SUB_W'(1);
                            end
                        end
                    end
                    R_STOP: begin
                        if (tick) begin
                            if (sub == SUB_LAST) begin
                                sub    <= '0;
                                done   <= 1'b1;
                                dout   <= data;
                                perr_o <= pe;
                                ferr_o <= ~rx_s;
                                sbrk_o <= ~rx_s & ~any1;
                                state  <= rx_s ? R_IDLE : R_WAITHI;
                            end else begin
                                sub <= sub + SUB_W'(1);
                            end
                        end
                    end
                    R_WAITHI: begin
                        if (rx_s) state <= R_IDLE;
                    end
                    default: state <= R_IDLE;
                endcase
            end
        end
    end

    // long low-time counter, in oversampling ticks
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lowcnt <= '0;
            lbrk_o <= 1'b0;
        end else begin
            lbrk_o <= 1'b0;
            if (!rx_en || rx_s) begin
                lowcnt <= '0;
            end else if (tick && lowcnt != thresh) begin
                lowcnt <= lowcnt + LOW_W'(1);
                if (lowcnt == thresh - LOW_W'(1)) lbrk_o <= 1'b1;
            end
        end
    end
endmodule

// File: rtl/serial_link.sv
module serial_link
    import serial_link_pkg::*;
#(
    parameter int unsigned DIV_W = 16,
    parameter int unsigned OVS   = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [BUS_W-1:0]  bus_wdata,
    output logic [BUS_W-1:0]  bus_rdata,
    input  logic              rxd_i,
    output logic              txd_o,
    input  logic              peer_rdy_i,
    output logic              rx_rdy_o
);
    ctrl_t            ctrl;
    logic [DIV_W-1:0] div;
    logic [7:0]       hold;
    logic             hold_valid;
    logic [8:0]       rxbuf;
    logic             rdr;
    logic             perr_f, ferr_f, oerr_f, lbrk_f, sbrk_f;
    logic             rx_q1, rx_q2, pr_q1, pr_q2;

    logic             tick;
    logic             take;
    logic             tx_busy;
    logic             go_ok;
    logic [3:0]       nb;
    logic             par_on;
    logic [8:0]       hold_data;
    logic             wr_txd, rd_rxd, wr_stat;
    logic [4:0]       clr_mask;

    logic             rx_done, rx_perr, rx_ferr, rx_sbrk, rx_lbrk;
    logic [8:0]       rx_data;

    always_comb begin
        nb        = data_bits(ctrl);
        par_on    = parity_on(ctrl);
        go_ok     = ctrl.tx_en && (!ctrl.hs_en || pr_q2);
        hold_data = {ctrl.nine & ctrl.tb8,
                     (ctrl.len8 | ctrl.nine) ? hold[7] : 1'b0,
                     hold[6:0]};
        wr_txd    = bus_wr && (bus_addr == A_TXD);
        wr_stat   = bus_wr && (bus_addr == A_STAT);
        rd_rxd    = bus_rd && (bus_addr == A_RXD);
        clr_mask  = wr_stat ? bus_wdata[7:3] : 5'b0;
        rx_rdy_o  = ctrl.hs_en & ctrl.rx_en & ~rdr;
    end

    // input synchronizers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rx_q1 <= 1'b1;
            rx_q2 <= 1'b1;
            pr_q1 <= 1'b0;
            pr_q2 <= 1'b0;
        end else begin
            rx_q1 <= rxd_i;
            rx_q2 <= rx_q1;
            pr_q1 <= peer_rdy_i;
            pr_q2 <= pr_q1;
        end
    end

    // configuration and transmit holding register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl       <= '0;
            div        <= '0;
            hold       <= '0;
            hold_valid <= 1'b0;
        end else begin
            if (bus_wr && bus_addr == A_CTRL) ctrl <= ctrl_t'(bus_wdata[7:0]);
            if (bus_wr && bus_addr == A_BAUD) div  <= bus_wdata[DIV_W-1:0];
            if (wr_txd) begin
                hold       <= bus_wdata[7:0];
                hold_valid <= 1'b1;
            end else if (take) begin
                hold_valid <= 1'b0;
            end
        end
    end

    // receive buffer and sticky flags; setting wins over clearing
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rxbuf  <= '0;
            rdr    <= 1'b0;
            perr_f <= 1'b0;
            ferr_f <= 1'b0;
            oerr_f <= 1'b0;
            lbrk_f <= 1'b0;
            sbrk_f <= 1'b0;
        end else begin
            if (rx_done) begin
                rxbuf <= rx_data;
                rdr   <= 1'b1;
            end else if (rd_rxd) begin
                rdr <= 1'b0;
            end
            perr_f <= (rx_done & rx_perr) | (perr_f & ~clr_mask[0]);
            ferr_f <= (rx_done & rx_ferr) | (ferr_f & ~clr_mask[1]);
            oerr_f <= (rx_done & rdr)     | (oerr_f & ~clr_mask[2]);
            lbrk_f <= rx_lbrk             | (lbrk_f & ~clr_mask[3]);
            sbrk_f <= (rx_done & rx_sbrk) | (sbrk_f & ~clr_mask[4]);
        end
    end

    always_comb begin
        unique case (bus_addr)
            A_CTRL:  bus_rdata = {8'h00, ctrl};
            A_STAT:  bus_rdata = {8'h00, sbrk_f, lbrk_f, oerr_f, ferr_f, perr_f,
                                  ~tx_busy & ~hold_valid, ~hold_valid, rdr};
            A_TXD:   bus_rdata = {8'h00, hold};
            A_RXD:   bus_rdata = {7'h00, rxbuf};
            A_BAUD:  bus_rdata = BUS_W'(div);
            default: bus_rdata = '0;
        endcase
    end

    sl_baud_gen #(.DIV_W(DIV_W)) u_baud (
        .clk   (clk),
        .rst_n (rst_n),
        .div   (div),
        .tick  (tick)
    );

    sl_tx #(.OVS(OVS)) u_tx (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick       (tick),
        .go_ok      (go_ok),
        .nb         (nb),
        .par_on     (par_on),
        .par_odd    (ctrl.par_odd),
        .hold_valid (hold_valid),
        .hold_data  (hold_data),
        .take       (take),
        .txd        (txd_o),
        .busy       (tx_busy)
    );

    sl_rx #(.OVS(OVS), .MAX_M(12)) u_rx (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick    (tick),
        .rx_en   (ctrl.rx_en),
        .nb      (nb),
        .par_on  (par_on),
        .par_odd (ctrl.par_odd),
        .rx_s    (rx_q2),
        .done    (rx_done),
        .dout    (rx_data),
        .perr_o  (rx_perr),
        .ferr_o  (rx_ferr),
        .sbrk_o  (rx_sbrk),
        .lbrk_o  (rx_lbrk)
    );
endmodule

// File: rtl/serial_link_chk.sv
module serial_link_chk (
    input logic clk,
    input logic rst_n,
    input logic rx_done,
    input logic rdr,
    input logic rd_rxd,
    input logic oerr_f,
    input logic hs_en,
    input logic rx_rdy_o,
    input logic hold_valid,
    input logic pr_q2,
    input logic wr_txd,
    input logic tx_busy,
    input logic txd_o,
    input logic perr_f,
    input logic clr_perr
);
    // R4
    rdr_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_rxd && !rx_done |=> !rdr);

    // R7
    overrun_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rx_done && rdr |=> oerr_f);

    // R9
    rtr_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rx_done |=> !rx_rdy_o);

    // R10
    tx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hs_en && !pr_q2 && hold_valid && !tx_busy && !wr_txd |=> hold_valid && !tx_busy);

    // R8
    sticky_perr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        perr_f && !clr_perr |=> perr_f);

    // R2
    idle_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !tx_busy |-> txd_o);
endmodule

bind serial_link serial_link_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .rx_done    (rx_done),
    .rdr        (rdr),
    .rd_rxd     (rd_rxd),
    .oerr_f     (oerr_f),
    .hs_en      (ctrl.hs_en),
    .rx_rdy_o   (rx_rdy_o),
    .hold_valid (hold_valid),
    .pr_q2      (pr_q2),
    .wr_txd     (wr_txd),
    .tx_busy    (tx_busy),
    .txd_o      (txd_o),
    .perr_f     (perr_f),
    .clr_perr   (clr_mask[0])
);

// File: tb/serial_link_bench.sv
module serial_link_bench;
    localparam int CLK_P = 10;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        bus_wr, bus_rd;
    logic [2:0]  bus_addr;
    logic [15:0] bus_wdata, bus_rdata;
    logic        rxd_i, txd_o, peer_rdy_i, rx_rdy_o;

    int total = 0;
    int bad   = 0;
    int bitc  = 16;
    bit done_flag = 0;

    // transmit reference model state
    logic [11:0] fq_bits[$];
    int          fq_len[$];
    bit          in_fr = 0;
    int          cnt = 0;
    int          cur_len = 0;
    logic [11:0] cur_bits = '0;
    logic [11:0] act_bits = '0;
    bit          fr_bad = 0;

    always #(CLK_P/2) clk = ~clk;

    serial_link u_serial_link (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .rxd_i(rxd_i), .txd_o(txd_o), .peer_rdy_i(peer_rdy_i), .rx_rdy_o(rx_rdy_o)
    );

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    // callers are at a negedge
    task automatic reg_wr(input logic [2:0] a, input logic [15:0] d);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic reg_rd(input logic [2:0] a, output logic [15:0] d);
        bus_addr = a; bus_rd = 1'b1;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic build_frame(input int nb, input bit pe, input bit odd,
                               input logic [8:0] d, output logic [11:0] bits, output int len);
        logic p;
        bits = '0;
        p = odd;
        for (int i = 0; i < nb; i++) begin
            bits[1+i] = d[i];
            p ^= d[i];
        end
        len = 1 + nb;
        if (pe) begin
            bits[len] = p;
            len++;
        end
        bits[len] = 1'b1;
        len++;
    endtask

    task automatic expect_tx(input int nb, input bit pe, input bit odd, input logic [8:0] d);
        logic [11:0] b;
        int l;
        build_frame(nb, pe, odd, d, b, l);
        fq_bits.push_back(b);
        fq_len.push_back(l);
    endtask

    task automatic send_rx(input int nb, input bit pe, input bit odd, input logic [8:0] d,
                           input bit flip, input bit stopv);
        logic [11:0] b;
        int l;
        build_frame(nb, pe, odd, d, b, l);
        if (pe) b[l-2] = b[l-2] ^ flip;
        b[l-1] = stopv;
        for (int i = 0; i < l; i++) begin
            rxd_i = b[i];
            repeat (bitc) @(negedge clk);
        end
        rxd_i = 1'b1;
        repeat (2 * bitc) @(negedge clk);
    endtask

    // cycle-by-cycle comparison of the serial output with the expected frames
    always @(negedge clk) begin
        if (rst_n === 1'b1 && !done_flag) begin
            if (!in_fr && txd_o === 1'b0) begin
                in_fr = 1; cnt = 0; fr_bad = 0; act_bits = '0;
                if (fq_len.size() == 0) begin
                    total++; bad++;
                    $display("FAIL R10 unexpected start bit act=0 exp=1");
                    cur_bits = '1; cur_len = 12;
                end else begin
                    cur_bits = fq_bits.pop_front();
                    cur_len  = fq_len.pop_front();
                end
            end
            if (in_fr) begin
                if (txd_o !== cur_bits[cnt / bitc]) fr_bad = 1;
                if (cnt % bitc == bitc / 2) act_bits[cnt / bitc] = txd_o;
                cnt++;
                if (cnt == bitc * cur_len) begin
                    in_fr = 0;
                    total++;
                    if (fr_bad) begin
                        bad++;
                        $display("FAIL R1/R2 tx frame act=%b exp=%b", act_bits, cur_bits);
                    end
                end
            end
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done_flag) begin
            done_flag = 1;
            total++; bad++;
            $display("FAIL watchdog act=running exp=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [15:0] r;
        rst_n = 1'b0; rxd_i = 1'b1; peer_rdy_i = 1'b1;
        bus_wr = 1'b0; bus_rd = 1'b0; bus_addr = '0; bus_wdata = '0;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R14 reset state
        reg_rd(3'd1, r); chk("R14 status", r, 16'h0006);
        reg_rd(3'd0, r); chk("R14 ctrl", r, 16'h0000);
        chk("R14 txd", {15'b0, txd_o}, 16'h0001);
        chk("R14 rx_rdy", {15'b0, rx_rdy_o}, 16'h0000);

        reg_wr(3'd4, 16'd4); bitc = 64;
        reg_wr(3'd0, 16'h0007);

        // R4 plain receive
        send_rx(8, 0, 0, 9'h0A5, 0, 1);
        reg_rd(3'd1, r); chk("R4 ready set", r, 16'h0007);
        reg_rd(3'd3, r); chk("R4 data", r, 16'h00A5);
        reg_rd(3'd1, r); chk("R4 ready cleared", r, 16'h0006);

        // R9 ready output
        reg_wr(3'd0, 16'h0027);
        chk("R9 rtr idle", {15'b0, rx_rdy_o}, 16'h0001);
        send_rx(8, 0, 0, 9'h03C, 0, 1);
        chk("R9 rtr unread", {15'b0, rx_rdy_o}, 16'h0000);
        reg_rd(3'd3, r); chk("R9 data", r, 16'h003C);
        chk("R9 rtr after read", {15'b0, rx_rdy_o}, 16'h0001);

        // R5 parity, R8 sticky
        reg_wr(3'd0, 16'h000F);
        send_rx(8, 1, 0, 9'h003, 0, 1);
        reg_rd(3'd1, r); chk("R5 good parity", r, 16'h0007);
        reg_rd(3'd3, r); chk("R5 data", r, 16'h0003);
        send_rx(8, 1, 0, 9'h007, 1, 1);
        reg_rd(3'd1, r); chk("R5 bad parity", r, 16'h000F);
        reg_rd(3'd3, r);
        reg_rd(3'd1, r); chk("R8 flag held", r, 16'h000E);
        reg_wr(3'd1, 16'h0008);
        reg_rd(3'd1, r); chk("R8 flag cleared", r, 16'h0006);

        // R6 framing
        reg_wr(3'd0, 16'h0007);
        send_rx(8, 0, 0, 9'h055, 0, 0);
        reg_rd(3'd1, r); chk("R6 framing", r, 16'h0017);
        reg_rd(3'd3, r); chk("R6 data", r, 16'h0055);
        reg_wr(3'd1, 16'h00F8);

        // R7 overrun
        send_rx(8, 0, 0, 9'h011, 0, 1);
        send_rx(8, 0, 0, 9'h022, 0, 1);
        reg_rd(3'd1, r); chk("R7 overrun", r, 16'h0027);
        reg_rd(3'd3, r); chk("R7 newest kept", r, 16'h0022);
        reg_wr(3'd1, 16'h00F8);

        // R5 seven bits odd parity
        reg_wr(3'd0, 16'h001B);
        send_rx(7, 1, 1, 9'h041, 0, 1);
        reg_rd(3'd1, r); chk("R5 odd parity 7 bit", r, 16'h0007);
        reg_rd(3'd3, r); chk("R5 7 bit data", r, 16'h0041);

        // R12 short break
        reg_wr(3'd0, 16'h0007);
        send_rx(8, 0, 0, 9'h000, 0, 0);
        reg_rd(3'd1, r); chk("R12 short break", r, 16'h0097);
        reg_rd(3'd3, r);
        reg_wr(3'd1, 16'h00F8);

        // R11 long break, M = 10
        rxd_i = 1'b0;
        repeat (22 * bitc) @(negedge clk);
        reg_rd(3'd1, r); chk("R11 not yet at 2M+2", {15'b0, r[6]}, 16'h0000);
        repeat (2 * bitc - 1) @(negedge clk);
        reg_rd(3'd1, r); chk("R11 long break", {15'b0, r[6]}, 16'h0001);
        rxd_i = 1'b1;
        repeat (2 * bitc) @(negedge clk);
        reg_rd(3'd3, r);
        reg_wr(3'd1, 16'h00F8);
        reg_rd(3'd1, r); chk("R8 all cleared", r, 16'h0006);

        // R13 nine-bit receive, parity enable ignored
        reg_wr(3'd0, 16'h004F);
        send_rx(9, 0, 0, 9'h1A5, 0, 1);
        reg_rd(3'd1, r); chk("R13 no parity check", r, 16'h0007);
        reg_rd(3'd3, r); chk("R13 ninth bit", r, 16'h01A5);

        // R2/R3 transmit 8N1
        reg_wr(3'd0, 16'h0007);
        expect_tx(8, 0, 0, 9'h05A);
        reg_wr(3'd2, 16'h005A);
        reg_rd(3'd1, r); chk("R3 holding full", r, 16'h0000);
        repeat (2 * bitc) @(negedge clk);
        reg_rd(3'd1, r); chk("R3 shifter busy", r, 16'h0002);
        expect_tx(8, 0, 0, 9'h081);
        reg_wr(3'd2, 16'h0081);
        repeat (22 * bitc) @(negedge clk);
        reg_rd(3'd1, r); chk("R3 empty", r, 16'h0006);

        // R2 odd parity, even 7 bit; R13 ninth bit
        reg_wr(3'd0, 16'h001F);
        expect_tx(8, 1, 1, 9'h033);
        reg_wr(3'd2, 16'h0033);
        repeat (14 * bitc) @(negedge clk);
        reg_wr(3'd0, 16'h000B);
        expect_tx(7, 1, 0, 9'h045);
        reg_wr(3'd2, 16'h00C5);
        repeat (14 * bitc) @(negedge clk);
        reg_wr(3'd0, 16'h00CF);
        expect_tx(9, 0, 0, 9'h10F);
        reg_wr(3'd2, 16'h000F);
        repeat (14 * bitc) @(negedge clk);

        // R1 other divisor
        reg_wr(3'd0, 16'h0007);
        reg_wr(3'd4, 16'd3); bitc = 48;
        expect_tx(8, 0, 0, 9'h096);
        reg_wr(3'd2, 16'h0096);
        repeat (14 * bitc) @(negedge clk);

        // R10 hold while peer not ready
        reg_wr(3'd0, 16'h0027);
        peer_rdy_i = 1'b0;
        repeat (4) @(negedge clk);
        reg_wr(3'd2, 16'h0044);
        repeat (15 * bitc) @(negedge clk);
        reg_rd(3'd1, r); chk("R10 data held", r, 16'h0000);
        chk("R10 line idle", {15'b0, txd_o}, 16'h0001);
        expect_tx(8, 0, 0, 9'h044);
        peer_rdy_i = 1'b1;
        repeat (14 * bitc) @(negedge clk);
        reg_rd(3'd1, r); chk("R10 sent after ready", r, 16'h0006);

        chk("R2 all frames seen", 16'(fq_len.size()), 16'h0000);

        if (!done_flag) begin
            done_flag = 1;
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule